// File: doc/BRIEF.md
# Four-bit up/down counter and bidirectional shift register

This block is a small synchronous register with eight operating modes. A 3-bit mode input selects one operation for each rising clock edge. The register can load a preset word, count up or down modulo 2^WIDTH, shift toward the high bit or toward the low bit, invert itself, clear itself, or hold. Two active-low enables gate the two counting modes, and an asynchronous reset clears the register at any time.

Identical stages can be chained. The trickle enable input also supplies the serial bit that enters the low end during an upward shift. The active-low terminal-count output marks the end of the count in the counting modes and carries the top bit in the shifting modes. Because of this, the terminal-count output of one stage can drive the trickle input of the next, for wide counters and for long shift chains alike. Complementary data outputs are provided next to the true outputs.

Top module: `updn_shift_reg`

## Requirements
- R1: While `arst` is high the register reads zero, whatever the clock and the other inputs are doing.
- R2: With `mode` = 000, a rising edge copies `preset` into `q`.
- R3: With `mode` = 001 and both `cep_n` and `cet_n` low, a rising edge adds one to `q`, and the all-ones value wraps to zero.
- R4: With `mode` = 010 and both enables low, a rising edge subtracts one from `q`, and zero wraps to all ones.
- R5: In modes 001 and 010, if either `cep_n` or `cet_n` is high, `q` keeps its value across the edge.
- R6: With `mode` = 011, a rising edge moves every bit one place toward the top bit: q[i] takes q[i-1], and q[0] takes the level on `cet_n`.
- R7: With `mode` = 100, a rising edge moves every bit one place toward bit 0: q[i] takes q[i+1], and the top bit takes `sin_dn`.
- R8: With `mode` = 101, a rising edge inverts every bit of `q`.
- R9: With `mode` = 110, a rising edge clears `q` to zero.
- R10: With `mode` = 111, `q` holds. In all modes other than 001 and 010, the two enables have no effect.
- R11: In mode 001, `tc_n` is low exactly when `cet_n` is low and `q` is all ones. In mode 010, `tc_n` is low exactly when `cet_n` is low and `q` is zero. In every other case within these two modes, `tc_n` is high.
- R12: In modes 011 and 100, `tc_n` equals the top bit of `q`. In modes 000, 101, 110 and 111 it is high.
- R13: `q_n` is always the bitwise inverse of `q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| arst | input | 1 | Asynchronous clear, active high, overrides all other inputs |
| mode | input | 3 | Operation select (encoding given in the requirements) |
| cep_n | input | 1 | Parallel count enable, active low |
| cet_n | input | 1 | Trickle count enable (active low), also the serial input for an upward shift |
| sin_dn | input | 1 | Serial input for a downward shift, entering at the top bit |
| preset | input | WIDTH | Parallel load word |
| q | output | WIDTH | Register contents |
| q_n | output | WIDTH | Inverted register contents |
| tc_n | output | 1 | Terminal count (active low), or the top bit while shifting |

## Verification
A corrupted register value shows on `q` and `q_n` at the very next negative clock phase. It also spreads: every later count, shift or inversion is computed from the wrong value, so a single upset keeps producing miscompares until a load, a clear or a reset repairs it. A fault in the terminal-count decode shows only when the count sits at all ones or zero, or while shifting. For that reason the stimulus drives the counter through both wrap points, and it toggles the trickle enable exactly at those points.

// File: rtl/updn_shift_reg.sv
module updn_shift_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             arst,
  input  logic [2:0]       mode,
  input  logic             cep_n,
  input  logic             cet_n,
  input  logic             sin_dn,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_n,
  output logic             tc_n
);
  localparam logic [WIDTH-1:0] ALL1 = '1;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  typedef enum logic [2:0] {
    M_LOAD = 3'd0, M_UP = 3'd1, M_DN = 3'd2, M_SHU = 3'd3,
    M_SHD  = 3'd4, M_CPL = 3'd5, M_CLR = 3'd6, M_HOLD = 3'd7
  } mode_e;

  mode_e m;
  logic  cnt_en;

  assign m      = mode_e'(mode);
  assign cnt_en = !cep_n && !cet_n;
  assign q_n    = ~q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) q <= '0;
    else begin
      case (m)
        M_LOAD: q <= preset;
        M_UP:   if (cnt_en) q <= q + ONE;
        M_DN:   if (cnt_en) q <= q - ONE;
        M_SHU:  q <= {q[WIDTH-2:0], cet_n};
        M_SHD:  q <= {sin_dn, q[WIDTH-1:1]};
        M_CPL:  q <= ~q;
        M_CLR:  q <= '0;
        default: q <= q;
      endcase
    end
  end

  always_comb begin
    case (m)
      M_UP:         tc_n = !(!cet_n && (q == ALL1));
      M_DN:         tc_n = !(!cet_n && (q == '0));
      M_SHU, M_SHD: tc_n = q[WIDTH-1];
      default:      tc_n = 1'b1;
    endcase
  end
endmodule

// File: rtl/updn_shift_reg_chk.sv
module updn_shift_reg_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             arst,
  input logic [2:0]       mode,
  input logic             cep_n,
  input logic             cet_n,
  input logic             sin_dn,
  input logic [WIDTH-1:0] preset,
  input logic [WIDTH-1:0] q,
  input logic             tc_n
);
  localparam logic [WIDTH-1:0] ALL1 = '1;

  // R1
  reset_clear_chk: assert property (@(posedge clk) arst |-> q == '0);
  // R2
  load_chk: assert property (@(posedge clk) disable iff (arst)
    mode == 3'd0 |=> q == $past(preset));
  // R3
  count_up_chk: assert property (@(posedge clk) disable iff (arst)
    (mode == 3'd1 && !cep_n && !cet_n) |=> q == WIDTH'($past(q) + 1'b1));
  // R4
  count_dn_chk: assert property (@(posedge clk) disable iff (arst)
    (mode == 3'd2 && !cep_n && !cet_n) |=> q == WIDTH'($past(q) - 1'b1));
  // R5
  gated_hold_chk: assert property (@(posedge clk) disable iff (arst)
    ((mode == 3'd1 || mode == 3'd2) && (cep_n || cet_n)) |=> $stable(q));
  // R6
  shift_up_chk: assert property (@(posedge clk) disable iff (arst)
    mode == 3'd3 |=> q == {$past(q[WIDTH-2:0]), $past(cet_n)});
  // R7
  shift_dn_chk: assert property (@(posedge clk) disable iff (arst)
    mode == 3'd4 |=> q == {$past(sin_dn), $past(q[WIDTH-1:1])});
  // R8
  invert_chk: assert property (@(posedge clk) disable iff (arst)
    mode == 3'd5 |=> q == ~$past(q));
  // R9
  sync_clear_chk: assert property (@(posedge clk) disable iff (arst)
    mode == 3'd6 |=> q == '0);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (arst)
    mode == 3'd7 |=> $stable(q));
  // R11
  tc_up_end_chk: assert property (@(posedge clk) disable iff (arst)
    (mode == 3'd1 && !cet_n && q == ALL1) |-> !tc_n);
  // R11
  tc_count_idle_chk: assert property (@(posedge clk) disable iff (arst)
    ((mode == 3'd1 && q != ALL1) || (mode == 3'd2 && q != '0) ||
     ((mode == 3'd1 || mode == 3'd2) && cet_n)) |-> tc_n);
  // R12
  tc_shift_chk: assert property (@(posedge clk) disable iff (arst)
    (mode == 3'd3 || mode == 3'd4) |-> tc_n == q[WIDTH-1]);
endmodule

bind updn_shift_reg updn_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .arst(arst), .mode(mode), .cep_n(cep_n), .cet_n(cet_n),
  .sin_dn(sin_dn), .preset(preset), .q(q), .tc_n(tc_n)
);

// File: tb/updn_shift_reg_bench.sv
`timescale 1ns/1ps
module updn_shift_reg_bench;
  localparam int W = 4;
  localparam int MOD = 1 << W;

  logic clk = 1'b0;
  logic arst = 1'b1;
  logic [2:0] mode = 3'd7;
  logic cep_n = 1'b1, cet_n = 1'b1, sin_dn = 1'b0;
  logic [W-1:0] preset = '0;
  logic [W-1:0] q, q_n;
  logic tc_n;

  int checks = 0;
  int fails = 0;
  int ref_q = 0;
  bit done = 0;

  updn_shift_reg #(.WIDTH(W)) u_updn_shift_reg (
    .clk(clk), .arst(arst), .mode(mode), .cep_n(cep_n), .cet_n(cet_n),
    .sin_dn(sin_dn), .preset(preset), .q(q), .q_n(q_n), .tc_n(tc_n)
  );

  always #2 clk = ~clk;

  // behavioural reference
  always @(posedge clk or posedge arst) begin
    if (arst) ref_q = 0;
    else begin
      case (mode)
        3'd0: ref_q = int'(preset);
        3'd1: if (!cep_n && !cet_n) ref_q = (ref_q + 1) % MOD;
        3'd2: if (!cep_n && !cet_n) ref_q = (ref_q + MOD - 1) % MOD;
        3'd3: ref_q = ((ref_q * 2) % MOD) + (cet_n ? 1 : 0);
        3'd4: ref_q = (ref_q / 2) + (sin_dn ? MOD / 2 : 0);
        3'd5: ref_q = MOD - 1 - ref_q;
        3'd6: ref_q = 0;
        default: ;
      endcase
    end
  end

  function automatic string q_tag();
    if (arst) return "R1";
    case (mode)
      3'd0: return "R2";
      3'd1: return (cep_n || cet_n) ? "R5" : "R3";
      3'd2: return (cep_n || cet_n) ? "R5" : "R4";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic int exp_tc();
    case (mode)
      3'd1: return (!cet_n && ref_q == MOD - 1) ? 0 : 1;
      3'd2: return (!cet_n && ref_q == 0) ? 0 : 1;
      3'd3, 3'd4: return ref_q / (MOD / 2);
      default: return 1;
    endcase
  endfunction

  // compare on every negative phase
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (int'(q) != ref_q) begin
        fails++;
        $display("FAIL %s q actual=%0d expected=%0d t=%0t", q_tag(), q, ref_q, $time);
      end
      if (int'(q_n) != MOD - 1 - ref_q) begin
        fails++;
        $display("FAIL R13 q_n actual=%0d expected=%0d", q_n, MOD - 1 - ref_q);
      end
      if (int'(tc_n) != exp_tc()) begin
        fails++;
        $display("FAIL %s tc_n actual=%0d expected=%0d mode=%0d",
                 (mode == 3'd1 || mode == 3'd2) ? "R11" : "R12", tc_n, exp_tc(), mode);
      end
    end
  end

  task automatic drive(input logic [2:0] m, input logic ep, input logic et,
                       input logic sd, input logic [W-1:0] p);
    @(posedge clk); #1;
    mode = m; cep_n = ep; cet_n = et; sin_dn = sd; preset = p;
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) drive(3'd0, 1'b0, 1'b0, 1'b1, 4'hA);   // R1 load ignored in reset
    @(posedge clk); #1; arst = 1'b0;
    drive(3'd0, 1'b1, 1'b1, 1'b0, 4'd13);             // R2
    repeat (5) drive(3'd1, 1'b0, 1'b0, 1'b0, 4'd0);   // R3 wrap, R11 end
    drive(3'd1, 1'b0, 1'b1, 1'b0, 4'd0);              // R5, R11 cet high
    drive(3'd1, 1'b1, 1'b0, 1'b0, 4'd0);              // R5
    drive(3'd0, 1'b0, 1'b0, 1'b0, 4'd2);
    repeat (5) drive(3'd2, 1'b0, 1'b0, 1'b0, 4'd0);   // R4 wrap, R11 zero
    drive(3'd0, 1'b0, 1'b0, 1'b0, 4'd15);
    drive(3'd1, 1'b0, 1'b1, 1'b0, 4'd0);              // R11 at end, cet high
    drive(3'd0, 1'b0, 1'b0, 1'b0, 4'd0);
    drive(3'd2, 1'b1, 1'b1, 1'b0, 4'd0);              // R5 at zero
    drive(3'd3, 1'b1, 1'b1, 1'b0, 4'd0);              // R6 serial 1s
    drive(3'd3, 1'b0, 1'b0, 1'b0, 4'd0);
    drive(3'd3, 1'b0, 1'b1, 1'b0, 4'd0);
    drive(3'd3, 1'b0, 1'b1, 1'b0, 4'd0);
    drive(3'd4, 1'b0, 1'b0, 1'b0, 4'd0);              // R7
    drive(3'd4, 1'b0, 1'b0, 1'b1, 4'd0);
    drive(3'd4, 1'b1, 1'b1, 1'b0, 4'd0);
    drive(3'd5, 1'b0, 1'b0, 1'b0, 4'd0);              // R8
    drive(3'd5, 1'b1, 1'b0, 1'b0, 4'd0);
    drive(3'd7, 1'b0, 1'b0, 1'b1, 4'd9);              // R10
    drive(3'd7, 1'b1, 1'b1, 1'b0, 4'd3);
    drive(3'd6, 1'b0, 1'b1, 1'b1, 4'd7);              // R9
    for (int i = 0; i < 4000; i++) begin
      drive(3'($urandom_range(0, 7)), 1'($urandom), 1'($urandom_range(0, 3) == 0),
            1'($urandom), 4'($urandom));
      if (i % 700 == 350) begin                        // R1 mid-run
        @(posedge clk); #1; arst = 1'b1;
        @(posedge clk); #1; arst = 1'b0;
      end
    end
    @(posedge clk); #1;
    @(negedge clk); #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule